// File: doc/BRIEF.md
# Bus Master Address Tenure Controller

This block runs the address phase of a split-transaction processor bus for a cache-based master. A miss or write-back queue hands it one transfer at a time. Each transfer carries a physical byte address, a read/write flag and a burst/single-beat flag. The controller then does the following in order:

- raises a bus request;
- waits for a grant that arrives while no other address tenure is in progress;
- drives the address with a one-cycle transfer-start strobe;
- holds the address unchanged until the target acknowledges it;
- releases the bus one cycle after the acknowledge, with no precharge cycle.

Tri-state is modelled with an explicit output-enable, and the address value is forced to zero while the enable is low.

On a burst the address is never incremented, because the target sequences the beats itself. The address is aligned as follows:

- A burst read drives the doubleword that holds the missed critical word.
- A burst write drives the first doubleword of the cache line.
- A single-beat transfer drives the full byte address.

While the controller is not driving the bus, it samples the address that another master places there. It does this only in the cycle that master's transfer-start is asserted, and hands the captured address to the coherency logic with a one-cycle valid pulse.

Top module: `addr_tenure_ctl`

## Requirements
- R1: After reset, `bus_req`, `addr_oe`, `ts_out`, `xfer_done` and `snp_valid` are 0, `addr_out` is 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `bus_req` is 1 and `req_ready` is 0, and both hold until the tenure starts.
- R3: A grant is qualified only when `bus_grant` is 1 and `tenure_busy` is 0 at the same clock edge. In the following cycle `addr_oe` and `ts_out` are both 1. A grant seen while `tenure_busy` is 1 leaves `addr_oe` at 0 and `bus_req` at 1.
- R4: `ts_out` is 1 for exactly the first cycle of the tenure. `addr_out`, `bus_write` and `bus_burst` stay unchanged while `addr_oe` is 1.
- R5: If `aack` is 1 at a clock edge while `addr_oe` is 1, then in the next cycle `addr_oe` is 0 and `xfer_done` is 1 for that one cycle.
- R6: A burst read (`req_burst`=1, `req_write`=0) drives the request address with bits [2:0] cleared.
- R7: A burst write (`req_burst`=1, `req_write`=1) drives the request address with bits [4:0] cleared, which is the first doubleword of a 32-byte line.
- R8: A single-beat transfer (`req_burst`=0) drives the request address unchanged. `bus_write` and `bus_burst` repeat the request flags while `addr_oe` is 1.
- R9: A clock edge with `ts_in`=1 and `addr_oe`=0 loads `addr_in` into `snp_addr`, and `snp_valid` is 1 for the next cycle only. On every other edge, including edges during the controller's own tenure, `snp_addr` keeps its value and `snp_valid` is 0.
- R10: `req_ready` returns to 1 only in the cycle after the `xfer_done` cycle.
- R11: `bus_req` is 0 whenever `addr_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_addr | input | 32 | Physical byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = cache-line burst, 0 = single beat |
| req_ready | output | 1 | Controller can accept a request |
| xfer_done | output | 1 | One-cycle pulse: address tenure finished |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| tenure_busy | input | 1 | Another address tenure is in progress |
| ts_out | output | 1 | Transfer-start strobe driven by this master |
| addr_out | output | 32 | Driven address (0 when not enabled) |
| addr_oe | output | 1 | Address bus output enable |
| bus_write | output | 1 | Write attribute of the driven transfer |
| bus_burst | output | 1 | Burst attribute of the driven transfer |
| aack | input | 1 | Address acknowledge from the target |
| ts_in | input | 1 | Transfer-start observed from another master |
| addr_in | input | 32 | Address observed on the bus |
| snp_valid | output | 1 | One-cycle pulse: snoop address captured |
| snp_addr | output | 32 | Last captured snoop address |

## Verification
A wrong state encoding or a missed transition shows up within one cycle at the ports, as a request, enable or strobe level that does not match the phase of the handshake. A stuck arbitration state keeps `bus_req` high and never raises `addr_oe`, and the grant-to-strobe check catches this in the cycle after the grant. A corrupted held address or wrong alignment mask is visible on `addr_out` in the strobe cycle, where the scoreboard compares it. A snoop enable gated wrongly shows either as a spurious `snp_valid` pulse during the controller's own tenure or as a missing pulse one cycle after a foreign transfer-start.

// File: rtl/addr_tenure_pkg.sv
package addr_tenure_pkg;
  typedef enum logic [1:0] {
    TEN_IDLE = 2'd0,
    TEN_ARB  = 2'd1,
    TEN_ADDR = 2'd2,
    TEN_FIN  = 2'd3
  } ten_state_t;
endpackage

// File: rtl/atc_addr_fmt.sv
module atc_addr_fmt #(
  parameter int ADDR_W   = 32,
  parameter int DW_LSB   = 3,
  parameter int LINE_LSB = 5
) (
  input  logic [ADDR_W-1:0] raw_addr,
  input  logic              is_write,
  input  logic              is_burst,
  output logic [ADDR_W-1:0] bus_addr
);
  localparam logic [ADDR_W-1:0] DW_MASK   = ~((ADDR_W'(1) << DW_LSB) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_LSB) - ADDR_W'(1));

  always_comb begin
    if (!is_burst)
      bus_addr = raw_addr;
    else if (is_write)
      bus_addr = raw_addr & LINE_MASK;
    else
      bus_addr = raw_addr & DW_MASK;
  end
endmodule

// File: rtl/atc_tenure_fsm.sv
module atc_tenure_fsm
  import addr_tenure_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] fmt_addr,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic              bus_grant,
  input  logic              tenure_busy,
  input  logic              aack,
  output logic              req_ready,
  output logic              xfer_done,
  output logic              bus_req,
  output logic              ts_out,
  output logic              addr_oe,
  output logic [ADDR_W-1:0] addr_out,
  output logic              bus_write,
  output logic              bus_burst
);
  ten_state_t        state_q, state_d;
  logic              first_q, first_d;
  logic [ADDR_W-1:0] hold_addr_q;
  logic              hold_wr_q, hold_bst_q;
  logic              accept, qual_grant, load_en;

  assign accept     = req_valid && (state_q == TEN_IDLE);
  assign qual_grant = bus_grant && !tenure_busy;
  assign load_en    = accept;

  always_comb begin
    state_d = state_q;
    first_d = 1'b0;
    case (state_q)
      TEN_IDLE: if (accept) state_d = TEN_ARB;
      TEN_ARB:  if (qual_grant) begin
                  state_d = TEN_ADDR;
                  first_d = 1'b1;
                end
      TEN_ADDR: if (aack) state_d = TEN_FIN;
      TEN_FIN:  state_d = TEN_IDLE;
      default:  state_d = TEN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TEN_IDLE;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr_q <= '0;
      hold_wr_q   <= 1'b0;
      hold_bst_q  <= 1'b0;
    end else if (load_en) begin
      hold_addr_q <= fmt_addr;
      hold_wr_q   <= req_write;
      hold_bst_q  <= req_burst;
    end
  end

  always_comb begin
    req_ready = (state_q == TEN_IDLE);
    xfer_done = (state_q == TEN_FIN);
    bus_req   = (state_q == TEN_ARB);
    addr_oe   = (state_q == TEN_ADDR);
    ts_out    = addr_oe && first_q;
    addr_out  = addr_oe ? hold_addr_q : '0;
    bus_write = addr_oe && hold_wr_q;
    bus_burst = addr_oe && hold_bst_q;
  end
endmodule

// File: rtl/atc_snoop_cap.sv
module atc_snoop_cap #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_in,
  input  logic              own_drive,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              snp_valid,
  output logic [ADDR_W-1:0] snp_addr
);
  logic              cap_en;
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;

  assign cap_en = ts_in && !own_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vld_q <= 1'b0;
    else
      vld_q <= cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr_q <= '0;
    else if (cap_en)
      addr_q <= addr_in;
  end

  assign snp_valid = vld_q;
  assign snp_addr  = addr_q;
endmodule

// File: rtl/addr_tenure_ctl.sv
module addr_tenure_ctl #(
  parameter int ADDR_W     = 32,
  parameter int DW_BYTES   = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_burst,
  output logic              req_ready,
  output logic              xfer_done,
  output logic              bus_req,
  input  logic              bus_grant,
  input  logic              tenure_busy,
  output logic              ts_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_oe,
  output logic              bus_write,
  output logic              bus_burst,
  input  logic              aack,
  input  logic              ts_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              snp_valid,
  output logic [ADDR_W-1:0] snp_addr
);
  localparam int DW_LSB   = $clog2(DW_BYTES);
  localparam int LINE_LSB = $clog2(LINE_BYTES);

  logic [ADDR_W-1:0] fmt_addr;

  atc_addr_fmt #(.ADDR_W(ADDR_W), .DW_LSB(DW_LSB), .LINE_LSB(LINE_LSB)) u_fmt (
    .raw_addr (req_addr),
    .is_write (req_write),
    .is_burst (req_burst),
    .bus_addr (fmt_addr)
  );

  atc_tenure_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .fmt_addr    (fmt_addr),
    .req_write   (req_write),
    .req_burst   (req_burst),
    .bus_grant   (bus_grant),
    .tenure_busy (tenure_busy),
    .aack        (aack),
    .req_ready   (req_ready),
    .xfer_done   (xfer_done),
    .bus_req     (bus_req),
    .ts_out      (ts_out),
    .addr_oe     (addr_oe),
    .addr_out    (addr_out),
    .bus_write   (bus_write),
    .bus_burst   (bus_burst)
  );

  atc_snoop_cap #(.ADDR_W(ADDR_W)) u_snp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ts_in     (ts_in),
    .own_drive (addr_oe),
    .addr_in   (addr_in),
    .snp_valid (snp_valid),
    .snp_addr  (snp_addr)
  );
endmodule

// File: rtl/atc_checker.sv
module atc_checker #(
  parameter int ADDR_W = 32,
  parameter int DW_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              xfer_done,
  input logic              bus_req,
  input logic              bus_grant,
  input logic              tenure_busy,
  input logic              ts_out,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_oe,
  input logic              bus_write,
  input logic              bus_burst,
  input logic              aack,
  input logic              ts_in,
  input logic              snp_valid
);
  localparam int DW_LSB = $clog2(DW_BYTES);

  AST_TS_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ts_out |-> addr_oe); // R3
  AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_grant && !tenure_busy) |=> ts_out); // R3
  AST_TS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ts_out |=> !ts_out); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe && !ts_out) |-> ($stable(addr_out) && $stable(bus_write) && $stable(bus_burst))); // R4
  AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe && aack) |=> (!addr_oe && xfer_done)); // R5
  AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe && bus_burst) |-> (addr_out[DW_LSB-1:0] == '0)); // R6
  AST_SNOOP_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> ($past(ts_in) && !$past(addr_oe))); // R9
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> req_ready); // R10
  AST_NO_REQ_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> !bus_req); // R11
endmodule

bind addr_tenure_ctl atc_checker #(.ADDR_W(ADDR_W), .DW_BYTES(DW_BYTES)) i_atc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .xfer_done   (xfer_done),
  .bus_req     (bus_req),
  .bus_grant   (bus_grant),
  .tenure_busy (tenure_busy),
  .ts_out      (ts_out),
  .addr_out    (addr_out),
  .addr_oe     (addr_oe),
  .bus_write   (bus_write),
  .bus_burst   (bus_burst),
  .aack        (aack),
  .ts_in       (ts_in),
  .snp_valid   (snp_valid)
);

// File: tb/test_addr_tenure_ctl.sv
module test_addr_tenure_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_burst;
  logic [31:0] req_addr;
  logic        req_ready, xfer_done, bus_req;
  logic        bus_grant, tenure_busy;
  logic        ts_out, addr_oe, bus_write, bus_burst;
  logic [31:0] addr_out;
  logic        aack, ts_in;
  logic [31:0] addr_in;
  logic        snp_valid;
  logic [31:0] snp_addr;

  int n_chk  = 0;
  int n_fail = 0;

  logic [33:0] exp_ten_q[$];
  logic [31:0] exp_snp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_tenure_ctl i_addr_tenure_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_burst(req_burst),
    .req_ready(req_ready), .xfer_done(xfer_done), .bus_req(bus_req),
    .bus_grant(bus_grant), .tenure_busy(tenure_busy),
    .ts_out(ts_out), .addr_out(addr_out), .addr_oe(addr_oe),
    .bus_write(bus_write), .bus_burst(bus_burst), .aack(aack),
    .ts_in(ts_in), .addr_in(addr_in), .snp_valid(snp_valid), .snp_addr(snp_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] model_addr(input logic [31:0] a, input logic wr, input logic bst);
    if (!bst) return a;
    if (wr)   return a & ~32'h1F;
    return a & ~32'h7;
  endfunction

  // monitor: tenure start and snoop results against queued expectations
  always @(negedge clk) begin
    if (rst_n && ts_out) begin
      if (exp_ten_q.size() == 0)
        chk(1'b0, "R6/R7/R8 unexpected tenure", {30'd0, ts_out}, 64'd0);
      else begin
        logic [33:0] e;
        e = exp_ten_q.pop_front();
        chk({bus_write, bus_burst, addr_out} == e, "R6/R7/R8 driven address/attributes",
            {30'd0, bus_write, bus_burst, addr_out}, {30'd0, e});
      end
    end
    if (rst_n && snp_valid) begin
      if (exp_snp_q.size() == 0)
        chk(1'b0, "R9 unexpected snoop pulse", {32'd0, snp_addr}, 64'd0);
      else begin
        logic [31:0] s;
        s = exp_snp_q.pop_front();
        chk(snp_addr == s, "R9 snoop address", {32'd0, snp_addr}, {32'd0, s});
      end
    end
  end

  task automatic do_xfer(input logic [31:0] a, input logic wr, input logic bst,
                         input int ack_wait, input bit busy_first, input bit snoop_mid);
    while (!req_ready) step();
    req_valid = 1'b1; req_addr = a; req_write = wr; req_burst = bst;
    step();
    req_valid = 1'b0; req_addr = 32'hDEAD_BEEF;
    chk(bus_req && !req_ready, "R2 request raised, ready dropped", {62'd0, bus_req, req_ready}, 64'h2);
    if (busy_first) begin
      bus_grant = 1'b1; tenure_busy = 1'b1;
      step();
      chk(!addr_oe && bus_req, "R3 grant while busy ignored", {62'd0, addr_oe, bus_req}, 64'h1);
      tenure_busy = 1'b0; bus_grant = 1'b0;
      step();
      chk(bus_req && !req_ready, "R2 request held", {62'd0, bus_req, req_ready}, 64'h2);
    end
    exp_ten_q.push_back({wr, bst, model_addr(a, wr, bst)});
    bus_grant = 1'b1;
    step();
    bus_grant = 1'b0;
    chk(addr_oe && ts_out, "R3 strobe and enable after qualified grant", {62'd0, addr_oe, ts_out}, 64'h3);
    chk(!bus_req, "R11 request dropped at tenure start", {63'd0, bus_req}, 64'd0);
    if (snoop_mid) begin
      ts_in = 1'b1; addr_in = 32'h5555_AAAA;
      step();
      ts_in = 1'b0;
      chk(!ts_out && addr_oe, "R4 strobe one cycle only", {62'd0, ts_out, addr_oe}, 64'h1);
      step();
      chk(!snp_valid, "R9 own tenure snoop ignored", {63'd0, snp_valid}, 64'd0);
      chk(addr_out == model_addr(a, wr, bst), "R4 address held", {32'd0, addr_out},
          {32'd0, model_addr(a, wr, bst)});
    end else begin
      for (int i = 0; i < ack_wait; i++) begin
        step();
        chk(!ts_out && addr_oe && addr_out == model_addr(a, wr, bst),
            "R4 strobe low, address held", {31'd0, ts_out, addr_out}, {32'd0, model_addr(a, wr, bst)});
      end
    end
    aack = 1'b1;
    step();
    aack = 1'b0;
    chk(!addr_oe && xfer_done && !req_ready, "R5 release and done one cycle after ack",
        {61'd0, addr_oe, xfer_done, req_ready}, 64'h2);
    step();
    chk(req_ready && !xfer_done, "R10 ready after release", {62'd0, req_ready, xfer_done}, 64'h2);
  endtask

  task automatic do_snoop(input logic [31:0] a);
    exp_snp_q.push_back(a);
    ts_in = 1'b1; addr_in = a;
    step();
    ts_in = 1'b0; addr_in = ~a;
    chk(snp_valid && snp_addr == a, "R9 snoop captured on strobe", {31'd0, snp_valid, snp_addr}, {31'd0, 1'b1, a});
    step();
    chk(!snp_valid && snp_addr == a, "R9 non-strobe address ignored", {31'd0, snp_valid, snp_addr}, {32'd0, a});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_burst = 1'b0;
    bus_grant = 1'b0; tenure_busy = 1'b0; aack = 1'b0; ts_in = 1'b0; addr_in = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(!bus_req && !addr_oe && !ts_out && !xfer_done && !snp_valid && req_ready && addr_out == 0,
        "R1 reset state", {57'd0, bus_req, addr_oe, ts_out, xfer_done, snp_valid, req_ready, |addr_out}, 64'h2);
    rst_n = 1'b1;
    step();
    chk(req_ready && !bus_req, "R1 idle after reset release", {62'd0, req_ready, bus_req}, 64'h2);

    do_xfer(32'h1000_0A5D, 1'b0, 1'b1, 2, 1'b0, 1'b0); // R6 burst read
    do_xfer(32'h2000_017B, 1'b1, 1'b1, 0, 1'b1, 1'b0); // R7 burst write, busy grant
    do_xfer(32'h3000_0043, 1'b0, 1'b0, 1, 1'b0, 1'b1); // R8 single read, snoop mid-tenure
    do_xfer(32'h4000_00FF, 1'b1, 1'b0, 3, 1'b0, 1'b0); // R8 single write
    do_snoop(32'hCAFE_0120);
    // R9: bus address wiggles without strobe
    addr_in = 32'h0BAD_0BAD;
    step();
    chk(!snp_valid && snp_addr == 32'hCAFE_0120, "R9 no strobe, no capture",
        {31'd0, snp_valid, snp_addr}, {32'd0, 32'hCAFE_0120});
    do_snoop(32'h0000_0FF8);
    do_xfer(32'hFFFF_FFFF, 1'b1, 1'b1, 1, 1'b0, 1'b0); // R7 top of space
    do_xfer(32'hFFFF_FFFF, 1'b0, 1'b1, 0, 1'b0, 1'b0); // R6 top of space
    step();
    chk(exp_ten_q.size() == 0 && exp_snp_q.size() == 0, "R3/R9 all expected items seen",
        64'(exp_ten_q.size() + exp_snp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule